// File: doc/BRIEF.md
# Byte-Wide SPI Master Controller with Sticky Status Flags

This controller moves one data word at a time over a four-wire serial link while acting as bus master. Software talks to it through three registers on a small synchronous bus: a control register, a read-only status register and a data register. Writing the data register in master mode loads the word straight into the shift register and starts the transfer. The received word is placed in a separate receive buffer on the last serial clock of the transfer, and that buffer is what a data read returns.

Three sticky flags report what happened: transfer complete, write collision and mode fault. Software can only clear a flag with an ordered two-access sequence that starts with a status read. An access to any other register in between cancels the sequence. A mode fault occurs when the slave-select input is pulled low while the block is master. The block then leaves master mode, turns off its serial output drivers and refuses to re-enter master mode until the fault has been cleared. A single interrupt line reports completion and faults when interrupts are enabled.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After reset the status register reads 00h, the control register reads 00h, `irq` is 0, `spi_oe` is 0 and `sclk_o` is 0.
- R2: Register addresses are 0 control, 1 status and 2 data; address 3 reads as zero. Control bit 0 enables the block, bit 1 selects master mode and bit 2 enables the interrupt; only these bits are stored and read back. In the status register bit 7 is transfer complete, bit 6 is write collision and bit 4 is mode fault; all other bits read 0.
- R3: A data write accepted in master mode with the block enabled sends DATA_W bits, MSB first. `sclk_o` idles low and has a period of CLK_DIV system clocks. `mosi_o` changes only on falling edges of `sclk_o`, and `miso_i` is sampled on rising edges.
- R4: When a transfer ends, the transfer-complete flag is set and the received word is copied into the receive buffer. Data reads return the buffer, so during the next transfer they still return the previous word.
- R5: The transfer-complete and write-collision flags clear only when a status read that saw them set is followed by a read or write of the data register. A control or unmapped access in between cancels the sequence.
- R6: While the transfer-complete flag is set, every data write is ignored. No transfer starts, no collision is flagged, and this includes the data write that completes the clearing sequence.
- R7: A data write while a transfer is running sets the write-collision flag and leaves the running transfer's bits unchanged.
- R8: A low `ss_n_in` (after SYNC_STAGES synchronizer flops) while enabled as master sets the mode-fault flag. It clears the enable and master control bits, drops `spi_oe` and aborts any running transfer without setting transfer complete.
- R9: The mode-fault flag clears only when a status read that saw it set is followed by a control write; a data access in between cancels the sequence. While the fault is set and not armed for clearing, control writes cannot set the enable or master bits.
- R10: `irq` is 1 exactly when the interrupt-enable bit is set and transfer complete or mode fault is set.
- R11: A data write while not enabled as master is ignored: no serial clock, no flag change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the addressed register (combinational) |
| irq | output | 1 | Interrupt request |
| ss_n_in | input | 1 | Slave-select sense input, low means another master claims the bus |
| miso_i | input | 1 | Serial data in |
| sclk_o | output | 1 | Serial clock out |
| mosi_o | output | 1 | Serial data out |
| spi_oe | output | 1 | Output enable for the serial clock and data drivers |

## Verification
The embedded properties check several rules on every cycle. The serial clock never leaves its idle level without a transfer. A completion flag rises only after the shifter's end pulse, and a collision flag rises only during a transfer. A data write while completion is pending never starts a transfer, and the output drivers stay off whenever a fault is pending. Other behaviour can only be shown by the bench scenarios: the MOSI bit order, the sampling of MISO into the receive buffer, the buffer staying stale during a transfer, and the cancellation of clearing sequences by an intervening access. The same holds for the lock-out of master mode until a fault is cleared, which the bench checks register by register at the ports.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

   // control register bit positions
   localparam int CTRL_EN   = 0;
   localparam int CTRL_MSTR = 1;
   localparam int CTRL_IEN  = 2;

   // status register bit positions
   localparam int ST_DONE  = 7;
   localparam int ST_WCOL  = 6;
   localparam int ST_FAULT = 4;

endpackage

// File: rtl/spi_flag_sync.sv
module spi_flag_sync #(
   parameter int STAGES = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= RESET_VAL;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= RESET_VAL;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];

endmodule

// File: rtl/spi_flag_shifter.sv
module spi_flag_shifter #(
   parameter int DATA_W  = 8,
   parameter int CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] load_data,
   input  logic              abort,
   input  logic              miso,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic              xfer_done,
   output logic [DATA_W-1:0] rx_buf
);

   localparam int HALF = CLK_DIV / 2;
   localparam int CW   = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
   localparam int BW   = $clog2(DATA_W);
   localparam logic [CW-1:0] RISE_AT  = CW'(HALF - 1);
   localparam logic [CW-1:0] FALL_AT  = CW'(CLK_DIV - 1);
   localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

   logic [CW-1:0]     div_q;
   logic [BW-1:0]     bit_q;
   logic [DATA_W-1:0] sh_q;
   logic [DATA_W-1:0] rx_q;
   logic              samp_q;
   logic              sclk_q;
   logic              busy_q;
   logic              done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         bit_q  <= '0;
         sh_q   <= '0;
         rx_q   <= '0;
         samp_q <= 1'b0;
         sclk_q <= 1'b0;
         busy_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (abort) begin
            busy_q <= 1'b0;
            sclk_q <= 1'b0;
            div_q  <= '0;
         end else if (start && !busy_q) begin
            sh_q   <= load_data;
            busy_q <= 1'b1;
            div_q  <= '0;
            bit_q  <= '0;
            sclk_q <= 1'b0;
         end else if (busy_q) begin
            if (div_q == RISE_AT) begin
               sclk_q <= 1'b1;
               samp_q <= miso;
               div_q  <= div_q + CW'(1);
            end else if (div_q == FALL_AT) begin
               sclk_q <= 1'b0;
               div_q  <= '0;
               sh_q   <= {sh_q[DATA_W-2:0], samp_q};
               if (bit_q == LAST_BIT) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  rx_q   <= {sh_q[DATA_W-2:0], samp_q};
               end else begin
                  bit_q <= bit_q + BW'(1);
               end
            end else begin
               div_q <= div_q + CW'(1);
            end
         end
      end
   end

   assign busy      = busy_q;
   assign sclk      = sclk_q;
   assign mosi      = sh_q[DATA_W-1];
   assign xfer_done = done_q;
   assign rx_buf    = rx_q;

   // R3
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);

endmodule

// File: rtl/spi_flag_regs.sv
module spi_flag_regs
   import spi_flag_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              busy,
   input  logic              xfer_done,
   input  logic              ss_low,
   input  logic [DATA_W-1:0] rx_buf,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              start,
   output logic              fault_evt,
   output logic              master_on,
   output logic              ien,
   output logic              done_flag,
   output logic              wcol_flag,
   output logic              fault_flag
);

   logic en_q, mstr_q, ien_q;
   logic done_q, wcol_q, fault_q;
   logic arm_done_q, arm_wcol_q, arm_fault_q;

   logic sel_ctrl, sel_stat, sel_data;
   logic acc, dr_acc, dr_wr, ctrl_wr, st_rd, coll;

   always_comb begin
      sel_ctrl = (bus_addr == REG_CTRL);
      sel_stat = (bus_addr == REG_STAT);
      sel_data = (bus_addr == REG_DATA);
      acc      = bus_rd | bus_wr;
      dr_acc   = acc & sel_data;
      dr_wr    = bus_wr & sel_data;
      ctrl_wr  = bus_wr & sel_ctrl;
      st_rd    = bus_rd & sel_stat;
   end

   assign master_on = en_q & mstr_q;
   assign fault_evt = master_on & ss_low;
   assign start     = dr_wr & !done_q & !busy & master_on & !fault_evt;
   assign coll      = dr_wr & !done_q & busy;

   // arming of the two-step clearing sequences
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         arm_done_q  <= 1'b0;
         arm_wcol_q  <= 1'b0;
         arm_fault_q <= 1'b0;
      end else if (st_rd) begin
         arm_done_q  <= done_q;
         arm_wcol_q  <= wcol_q;
         arm_fault_q <= fault_q;
      end else if (acc) begin
         arm_done_q  <= 1'b0;
         arm_wcol_q  <= 1'b0;
         arm_fault_q <= 1'b0;
      end
   end

   // sticky flags: a hardware set wins over a same-cycle clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         wcol_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= xfer_done | (done_q  & !(dr_acc  & arm_done_q));
         wcol_q  <= coll      | (wcol_q  & !(dr_acc  & arm_wcol_q));
         fault_q <= fault_evt | (fault_q & !(ctrl_wr & arm_fault_q));
      end
   end

   // control register; a fault forces master mode off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         mstr_q <= 1'b0;
         ien_q  <= 1'b0;
      end else if (fault_evt) begin
         en_q   <= 1'b0;
         mstr_q <= 1'b0;
         if (ctrl_wr) ien_q <= bus_wdata[CTRL_IEN];
      end else if (ctrl_wr) begin
         ien_q <= bus_wdata[CTRL_IEN];
         if (!fault_q || arm_fault_q) begin
            en_q   <= bus_wdata[CTRL_EN];
            mstr_q <= bus_wdata[CTRL_MSTR];
         end else begin
            en_q   <= 1'b0;
            mstr_q <= 1'b0;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      unique case (bus_addr)
         REG_CTRL: begin
            bus_rdata[CTRL_EN]   = en_q;
            bus_rdata[CTRL_MSTR] = mstr_q;
            bus_rdata[CTRL_IEN]  = ien_q;
         end
         REG_STAT: begin
            bus_rdata[ST_DONE]  = done_q;
            bus_rdata[ST_WCOL]  = wcol_q;
            bus_rdata[ST_FAULT] = fault_q;
         end
         REG_DATA: bus_rdata = rx_buf;
         default:  bus_rdata = '0;
      endcase
   end

   assign ien        = ien_q;
   assign done_flag  = done_q;
   assign wcol_flag  = wcol_q;
   assign fault_flag = fault_q;

   // R4
   done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> $past(xfer_done));

   // R5
   done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !dr_acc) |=> done_q);

   // R7
   wcol_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wcol_q) |-> $past(busy));

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
   import spi_flag_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int CLK_DIV     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              ss_n_in,
   input  logic              miso_i,
   output logic              sclk_o,
   output logic              mosi_o,
   output logic              spi_oe
);

   generate
      if (DATA_W < 8) begin : g_bad_width
         $error("DATA_W must be at least 8 to hold the status layout");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be an even value of at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic ss_n_s;
   logic busy, sclk, mosi, xfer_done;
   logic [DATA_W-1:0] rx_buf;
   logic start, fault_evt, master_on, ien;
   logic done_flag, wcol_flag, fault_flag;

   spi_flag_sync #(
      .STAGES   (SYNC_STAGES),
      .RESET_VAL(1'b1)
   ) u_ss_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (ss_n_in),
      .q    (ss_n_s)
   );

   spi_flag_regs #(
      .DATA_W(DATA_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_rd    (bus_rd),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .busy      (busy),
      .xfer_done (xfer_done),
      .ss_low    (!ss_n_s),
      .rx_buf    (rx_buf),
      .bus_rdata (bus_rdata),
      .start     (start),
      .fault_evt (fault_evt),
      .master_on (master_on),
      .ien       (ien),
      .done_flag (done_flag),
      .wcol_flag (wcol_flag),
      .fault_flag(fault_flag)
   );

   spi_flag_shifter #(
      .DATA_W (DATA_W),
      .CLK_DIV(CLK_DIV)
   ) u_shift (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .load_data(bus_wdata),
      .abort    (fault_evt),
      .miso     (miso_i),
      .busy     (busy),
      .sclk     (sclk),
      .mosi     (mosi),
      .xfer_done(xfer_done),
      .rx_buf   (rx_buf)
   );

   assign spi_oe = master_on;
   assign sclk_o = sclk & master_on;
   assign mosi_o = mosi & master_on;
   assign irq    = ien & (done_flag | fault_flag);

   // R6
   done_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == REG_DATA && done_flag && !busy) |=> !busy);

   // R8
   fault_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_flag |-> !spi_oe);

   // R8
   fault_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_flag && !$past(fault_flag)) |-> !busy);

   // R7
   wcol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wcol_flag && !busy && !bus_rd && !bus_wr) |=> wcol_flag);

endmodule

// File: tb/spi_flag_ctrl_test.sv
module spi_flag_ctrl_test;
   import spi_flag_pkg::*;

   localparam int DW  = 8;
   localparam int DIV = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    bus_addr = 2'd0;
   logic          bus_rd = 1'b0;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          irq;
   logic          ss_n_in = 1'b1;
   logic          miso_i;
   logic          sclk_o, mosi_o, spi_oe;

   always #5 clk = ~clk;

   spi_flag_ctrl #(.DATA_W(DW), .CLK_DIV(DIV), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .ss_n_in(ss_n_in), .miso_i(miso_i), .sclk_o(sclk_o),
      .mosi_o(mosi_o), .spi_oe(spi_oe)
   );

   int  errors = 0;
   int  checks = 0;
   int  cyc = 0;
   int  sclk_rises = 0;
   bit  finished = 1'b0;

   always @(posedge clk) cyc++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // slave model: MSB presented before first rise, shifted on each fall
   logic [DW-1:0] slave_sh = '0;
   assign miso_i = slave_sh[DW-1];
   always @(negedge sclk_o) slave_sh = {slave_sh[DW-2:0], 1'b0};

   // scoreboard queues
   logic [DW-1:0] exp_mosi[$];
   logic [DW-1:0] exp_rx[$];

   // monitor of the serial output
   bit            mon_en = 1'b1;
   int            mon_bits = 0;
   int            last_rise = 0;
   logic [DW-1:0] mon_byte = '0;

   always @(posedge sclk_o) begin
      sclk_rises++;
      if (mon_en) begin
         if (mon_bits > 0) check("R3 sclk period", 32'(cyc - last_rise), DIV);
         last_rise = cyc;
         mon_byte  = {mon_byte[DW-2:0], mosi_o};
         mon_bits++;
         if (mon_bits == DW) begin
            mon_bits = 0;
            if (exp_mosi.size() == 0) check("R3 unexpected byte on mosi", 32'(mon_byte), 32'hFFFF);
            else check("R3 mosi byte MSB first", 32'(mon_byte), 32'(exp_mosi.pop_front()));
         end
      end
   end

   task automatic start_xfer(input logic [DW-1:0] tx, input logic [DW-1:0] sl);
      mon_bits = 0;
      slave_sh = sl;
      exp_mosi.push_back(tx);
      exp_rx.push_back(sl);
      wr(REG_DATA, tx);
   endtask

   // poll status until complete; returns last status seen (arms the clear)
   task automatic wait_done(output logic [DW-1:0] st);
      st = '0;
      for (int i = 0; i < 200; i++) begin
         rd(REG_STAT, st);
         if (st[ST_DONE]) break;
      end
   endtask

   task automatic finish_xfer(input string req);
      logic [DW-1:0] st, d;
      wait_done(st);
      check({req, " completion flag"}, 32'(st[ST_DONE]), 1);
      rd(REG_DATA, d);
      check({req, " received word"}, 32'(d), 32'(exp_rx.pop_front()));
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : stim
      logic [DW-1:0] d, st;
      int r0;

      idle(3);
      // R1 reset state
      rd(REG_STAT, d); check("R1 status after reset", 32'(d), 0);
      rd(REG_CTRL, d); check("R1 control after reset", 32'(d), 0);
      check("R1 irq after reset", 32'(irq), 0);
      check("R1 oe after reset", 32'(spi_oe), 0);
      check("R1 sclk after reset", 32'(sclk_o), 0);
      @(negedge clk); rst_n = 1'b1;
      idle(2);

      // R2 control storage and unmapped address
      wr(REG_CTRL, 8'hFF);
      rd(REG_CTRL, d); check("R2 control keeps only bits 2:0", 32'(d), 32'h07);
      rd(REG_NONE, d); check("R2 unmapped address reads zero", 32'(d), 0);

      // R11 data write without master mode
      wr(REG_CTRL, 8'h01);
      r0 = sclk_rises;
      wr(REG_DATA, 8'h5A);
      idle(50);
      check("R11 no serial clock outside master mode", 32'(sclk_rises - r0), 0);
      rd(REG_STAT, d); check("R11 status unchanged", 32'(d), 0);

      // R3 R4 basic transfers, several patterns
      wr(REG_CTRL, 8'h03);
      check("R3 drivers enabled in master mode", 32'(spi_oe), 1);
      start_xfer(8'hA5, 8'h3C); finish_xfer("R4 xfer A5/3C");
      start_xfer(8'h01, 8'h80); finish_xfer("R4 xfer 01/80");
      start_xfer(8'hFE, 8'h7F); finish_xfer("R4 xfer FE/7F");
      rd(REG_STAT, d); check("R5 flag cleared by status then data", 32'(d), 0);

      // R5 cancellation by an intervening control access
      start_xfer(8'hC3, 8'h96);
      wait_done(st);
      rd(REG_CTRL, d);
      rd(REG_DATA, d); check("R4 buffer holds last word", 32'(d), 32'h96);
      rd(REG_STAT, d); check("R5 control access cancels clear", 32'(d), 32'h80);
      // R6 data write while complete is ignored (also the clearing write)
      r0 = sclk_rises;
      wr(REG_DATA, 8'h55);
      idle(50);
      check("R6 no transfer while complete", 32'(sclk_rises - r0), 0);
      rd(REG_STAT, d); check("R6 status after inhibited write", 32'(d), 0);
      check("R6 mosi queue untouched", 32'(exp_mosi.size()), 0);
      rd(REG_DATA, d); check("R6 buffer after inhibited write", 32'(d), 32'h96);
      void'(exp_rx.pop_front());

      // R4 buffer stays stale mid-transfer; R7 collision
      start_xfer(8'h0F, 8'hF0);
      idle(6);
      rd(REG_DATA, d); check("R4 read mid-transfer returns old buffer", 32'(d), 32'h96);
      wr(REG_DATA, 8'h99);
      wait_done(st);
      check("R7 collision and completion flags", 32'(st), 32'hC0);
      rd(REG_DATA, d); check("R4 received word after collision", 32'(d), 32'(exp_rx.pop_front()));
      rd(REG_STAT, d); check("R7 collision cleared by sequence", 32'(d), 0);

      // R10 interrupt on completion
      wr(REG_CTRL, 8'h07);
      check("R10 irq low with no flag", 32'(irq), 0);
      start_xfer(8'h66, 8'h24);
      wait_done(st);
      idle(1);
      check("R10 irq on completion", 32'(irq), 1);
      rd(REG_DATA, d); check("R4 word with irq enabled", 32'(d), 32'(exp_rx.pop_front()));
      check("R10 irq drops after clear", 32'(irq), 0);

      // R8 mode fault while idle
      ss_n_in = 1'b0;
      idle(6);
      rd(REG_STAT, d); check("R8 fault flag set", 32'(d), 32'h10);
      rd(REG_CTRL, d); check("R8 master and enable cleared", 32'(d), 32'h04);
      check("R8 drivers off", 32'(spi_oe), 0);
      check("R10 irq on fault", 32'(irq), 1);
      ss_n_in = 1'b1;
      idle(4);

      // R9 lock-out and cancelled sequence
      wr(REG_CTRL, 8'h03);
      rd(REG_CTRL, d); check("R9 master blocked while fault pending", 32'(d), 0);
      rd(REG_STAT, d);
      rd(REG_DATA, d);
      wr(REG_CTRL, 8'h03);
      rd(REG_STAT, d); check("R9 data access cancels fault clear", 32'(d), 32'h10);
      wr(REG_CTRL, 8'h03);
      rd(REG_STAT, d); check("R9 fault cleared by status then control", 32'(d), 0);
      rd(REG_CTRL, d); check("R9 master restored", 32'(d), 32'h03);

      // R8 abort of a running transfer
      mon_en = 1'b0;
      slave_sh = 8'hAA;
      wr(REG_DATA, 8'h3E);
      idle(8);
      ss_n_in = 1'b0;
      idle(60);
      rd(REG_STAT, d); check("R8 abort leaves only fault", 32'(d), 32'h10);
      check("R8 sclk low after abort", 32'(sclk_o), 0);
      ss_n_in = 1'b1;
      idle(4);
      rd(REG_STAT, d);
      wr(REG_CTRL, 8'h03);
      mon_en = 1'b1;

      // recovery transfer
      start_xfer(8'h81, 8'h42); finish_xfer("R4 xfer after recovery");
      idle(4);
      check("R3 all mosi bytes observed", 32'(exp_mosi.size()), 0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule